// File: doc/BRIEF.md
# Receive Link Signal Monitor

This block watches a recovered serial receive path and decides, once per recovered character clock, whether the link carries a usable signal. It combines four inputs into one link-valid decision. Two are flags from outside the block: an amplitude comparator flag and a carrier-present flag. The third is a transition-density check that runs on the recovered bit stream. The fourth is a rate check that compares the recovered clock with a local reference clock. The result appears on an active-low fault output, which is registered in the recovered character clock domain.

The rate check counts recovered-clock cycles over a fixed window of reference-clock cycles and tests the count against a ppm tolerance band. When the count falls outside the band, a select output tells the clock recovery loop to follow the reference clock instead of the data. The select returns to data tracking once a full window measures in range. Both external flags are asynchronous and pass through a multi-flop synchronizer before they are used. The fault output clears only after a complete qualification window with every condition valid. A single bad cycle sets it again.

Top module: `rx_link_watch`

## Requirements
- R1: While reset is asserted, `link_fault_n` is 0 (fault) and `track_ref` is 1 (follow the reference clock).
- R2: `link_fault_n` rises to 1 once amplitude, carrier, transition density and rate have all been valid together for QUAL recovered cycles. QUAL is the nominal window count 2^WIN_LOG2·RATE_NUM/RATE_DEN.
- R3: When `amp_ok_async` drops, `link_fault_n` has not changed at the first `rec_clk` edge after the drop and is 0 no later than the third edge (SYNC_STAGES = 2).
- R4: When `carrier_async` drops, `link_fault_n` follows the same timing as in R3.
- R5: `rx_char` bit 0 is the earliest bit in time. A run of more than MAX_RUN identical consecutive bits, counted across character boundaries, drives `link_fault_n` to 0 within two edges. A run of exactly MAX_RUN does not.
- R6: A window count outside NOM−TOL to NOM+TOL sets `track_ref` to 1 and `link_fault_n` to 0. The window count is the number of `rec_clk` cycles between consecutive window marks, where one mark occurs every 2^WIN_LOG2 `ref_clk` cycles. NOM is the nominal count, and TOL = NOM·PPM_TOL/10^6.
- R7: After the rate returns to the band, `track_ref` goes back to 0 once a full window measures in range.
- R8: `link_fault_n` changes only on `rec_clk` edges. It holds its value while `rec_clk` is stopped, whatever the inputs do.
- R9: After any fault, `link_fault_n` stays 0 until a full QUAL-cycle run of valid conditions has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rec_clk | input | 1 | Recovered character clock |
| ref_clk | input | 1 | Local reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| amp_ok_async | input | 1 | Amplitude comparator flag, asynchronous |
| carrier_async | input | 1 | Carrier-present flag, asynchronous |
| rx_char | input | CHAR_W | Recovered bits of one character, bit 0 first |
| link_fault_n | output | 1 | Link fault, low means fault |
| track_ref | output | 1 | 1: clock recovery follows the reference clock |

## Verification
The bench builds the block with WIN_LOG2 = 10 and PPM_TOL = 20000, which gives a nominal window of 1024 cycles and a band of ±20 counts. These values let several lock, loss and relock sequences fit into a short run. A reference clock slowed by 10 % then produces counts far outside the band, while synchronizer jitter stays well inside it. CHAR_W = 10 and MAX_RUN = 20 are kept, so runs of exactly 20 and exactly 21 bits can be built across a two-character boundary. The bench also stops `rec_clk` in mid-run to show that the fault output holds.

// File: rtl/rlm_pkg.sv
package rlm_pkg;

   typedef struct packed {
      logic amp;
      logic carr;
      logic dens;
      logic freq;
   } link_cond_t;

   function automatic logic cond_all(input link_cond_t c);
      return c.amp & c.carr & c.dens & c.freq;
   endfunction

endpackage

// File: rtl/rlm_sync.sv
module rlm_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rlm_sync: STAGES must be 2 or more");
   end
   if (W < 1) begin : g_bad_width
      $error("rlm_sync: W must be positive");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/rlm_density.sv
module rlm_density #(
   parameter int CHAR_W  = 10,
   parameter int MAX_RUN = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CHAR_W-1:0] bits,
   output logic              dens_ok
);
   if (MAX_RUN < 1 || CHAR_W < 1) begin : g_bad_param
      $error("rlm_density: MAX_RUN and CHAR_W must be positive");
   end

   localparam int               RUN_W   = $clog2(MAX_RUN + 2);
   localparam logic [RUN_W-1:0] RUN_CAP = RUN_W'(MAX_RUN + 1);

   logic             last_q, last_d, over_d;
   logic [RUN_W-1:0] run_q, run_d;

   // walk the character in arrival order, carrying the run across words
   always_comb begin
      run_d  = run_q;
      last_d = last_q;
      over_d = 1'b0;
      for (int i = 0; i < CHAR_W; i++) begin
         if (bits[i] == last_d) begin
            if (run_d != RUN_CAP) run_d = run_d + 1'b1;
         end else begin
            run_d = RUN_W'(1);
         end
         last_d = bits[i];
         if (run_d == RUN_CAP) over_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= '0;
         last_q  <= 1'b0;
         dens_ok <= 1'b0;
      end else begin
         run_q   <= run_d;
         last_q  <= last_d;
         dens_ok <= !over_d;
      end
   end
endmodule

// File: rtl/rlm_freq_meter.sv
module rlm_freq_meter #(
   parameter int WIN_LOG2    = 16,
   parameter int LO_CNT      = 65510,
   parameter int HI_CNT      = 65562,
   parameter int SYNC_STAGES = 2
) (
   input  logic ref_clk,
   input  logic rec_clk,
   input  logic rst_n,
   output logic freq_ok
);
   if (LO_CNT < 1 || HI_CNT <= LO_CNT) begin : g_bad_band
      $error("rlm_freq_meter: band limits are inconsistent");
   end
   if (WIN_LOG2 < 2) begin : g_bad_win
      $error("rlm_freq_meter: WIN_LOG2 too small");
   end

   localparam int               CNT_W = $clog2(HI_CNT + 2);
   localparam logic [CNT_W-1:0] LO_V  = CNT_W'(LO_CNT);
   localparam logic [CNT_W-1:0] HI_V  = CNT_W'(HI_CNT);
   localparam logic [CNT_W-1:0] SAT_V = CNT_W'(HI_CNT + 1);

   // reference domain: a mark toggles once per window
   logic [WIN_LOG2-1:0] win_q;
   logic                mark_q;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         mark_q <= 1'b0;
      end else begin
         win_q <= win_q + 1'b1;
         if (&win_q) mark_q <= ~mark_q;
      end
   end

   // recovered domain: count cycles between synchronized marks
   logic             mark_s, mark_d1, mark_edge;
   logic [CNT_W-1:0] cnt_q;

   rlm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_mark_sync (
      .clk  (rec_clk),
      .rst_n(rst_n),
      .d    (mark_q),
      .q    (mark_s)
   );

   assign mark_edge = mark_s ^ mark_d1;

   always_ff @(posedge rec_clk or negedge rst_n) begin
      if (!rst_n) begin
         mark_d1 <= 1'b0;
         cnt_q   <= '0;
         freq_ok <= 1'b0;
      end else begin
         mark_d1 <= mark_s;
         if (mark_edge) begin
            freq_ok <= (cnt_q >= LO_V) && (cnt_q <= HI_V);
            cnt_q   <= CNT_W'(1);
         end else begin
            if (cnt_q != SAT_V) cnt_q <= cnt_q + 1'b1;
            if (cnt_q > HI_V) freq_ok <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/rlm_qualify.sv
module rlm_qualify #(
   parameter int QUAL = 65536
) (
   input  logic clk,
   input  logic rst_n,
   input  logic all_ok,
   output logic link_ok
);
   if (QUAL < 1) begin : g_bad_qual
      $error("rlm_qualify: QUAL must be positive");
   end

   localparam int             Q_W    = $clog2(QUAL + 1);
   localparam logic [Q_W-1:0] QUAL_V = Q_W'(QUAL);
   localparam logic [Q_W-1:0] LAST_V = Q_W'(QUAL - 1);

   logic [Q_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         link_ok <= 1'b0;
      end else if (!all_ok) begin
         cnt_q   <= '0;
         link_ok <= 1'b0;
      end else begin
         if (cnt_q != QUAL_V) cnt_q <= cnt_q + 1'b1;
         link_ok <= (cnt_q >= LAST_V);
      end
   end
endmodule

// File: rtl/rx_link_watch.sv
module rx_link_watch
   import rlm_pkg::*;
#(
   parameter int CHAR_W      = 10,
   parameter int MAX_RUN     = 20,
   parameter int WIN_LOG2    = 16,
   parameter int RATE_NUM    = 1,
   parameter int RATE_DEN    = 1,
   parameter int PPM_TOL     = 400,
   parameter int SYNC_STAGES = 2
) (
   input  logic              rec_clk,
   input  logic              ref_clk,
   input  logic              rst_n,
   input  logic              amp_ok_async,
   input  logic              carrier_async,
   input  logic [CHAR_W-1:0] rx_char,
   output logic              link_fault_n,
   output logic              track_ref
);
   localparam int NOM_CNT  = ((2 ** WIN_LOG2) * RATE_NUM) / RATE_DEN;
   localparam int TOL_CNT  = (NOM_CNT * PPM_TOL) / 1000000;
   localparam int LO_CNT   = NOM_CNT - TOL_CNT;
   localparam int HI_CNT   = NOM_CNT + TOL_CNT;
   localparam int QUAL_CYC = NOM_CNT;

   if (TOL_CNT < 2) begin : g_bad_tol
      $error("rx_link_watch: tolerance band narrower than synchronizer jitter");
   end
   if (RATE_DEN < 1 || RATE_NUM < 1) begin : g_bad_rate
      $error("rx_link_watch: rate ratio must be positive");
   end

   logic [1:0] flag_s;
   logic       amp_s, carr_s, dens_ok, freq_ok, all_ok, link_ok;
   link_cond_t cond;

   rlm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_flag_sync (
      .clk  (rec_clk),
      .rst_n(rst_n),
      .d    ({amp_ok_async, carrier_async}),
      .q    (flag_s)
   );

   assign amp_s  = flag_s[1];
   assign carr_s = flag_s[0];

   rlm_density #(.CHAR_W(CHAR_W), .MAX_RUN(MAX_RUN)) u_density (
      .clk    (rec_clk),
      .rst_n  (rst_n),
      .bits   (rx_char),
      .dens_ok(dens_ok)
   );

   rlm_freq_meter #(
      .WIN_LOG2   (WIN_LOG2),
      .LO_CNT     (LO_CNT),
      .HI_CNT     (HI_CNT),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_freq (
      .ref_clk(ref_clk),
      .rec_clk(rec_clk),
      .rst_n  (rst_n),
      .freq_ok(freq_ok)
   );

   always_comb begin
      cond.amp  = amp_s;
      cond.carr = carr_s;
      cond.dens = dens_ok;
      cond.freq = freq_ok;
   end

   assign all_ok = cond_all(cond);

   rlm_qualify #(.QUAL(QUAL_CYC)) u_qual (
      .clk    (rec_clk),
      .rst_n  (rst_n),
      .all_ok (all_ok),
      .link_ok(link_ok)
   );

   assign link_fault_n = link_ok;
   assign track_ref    = ~freq_ok;
endmodule

// File: rtl/rlm_checker.sv
module rlm_checker #(
   parameter int QUAL = 65536
) (
   input logic clk,
   input logic rst_n,
   input logic link_fault_n,
   input logic track_ref,
   input logic amp_s,
   input logic carr_s,
   input logic dens_ok,
   input logic freq_ok
);
   int ok_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ok_run <= 0;
      else if (amp_s && carr_s && dens_ok && freq_ok) begin
         if (ok_run < QUAL + 1) ok_run <= ok_run + 1;
      end else ok_run <= 0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         a_reset_r1 : assert (!link_fault_n && track_ref)
            else $error("reset state wrong");
      end
   end

   // R3 and R4: a bad synchronized flag forces a fault next cycle
   p_flag_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !(amp_s && carr_s) |=> !link_fault_n);

   p_density_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      !dens_ok |=> !link_fault_n);

   p_freq_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      !freq_ok |=> !link_fault_n);

   p_track_clear_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_fault_n) |-> !track_ref);

   p_window_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_fault_n) |-> (ok_run >= QUAL));
endmodule

bind rx_link_watch rlm_checker #(.QUAL(QUAL_CYC)) u_rlm_checker (
   .clk         (rec_clk),
   .rst_n       (rst_n),
   .link_fault_n(link_fault_n),
   .track_ref   (track_ref),
   .amp_s       (amp_s),
   .carr_s      (carr_s),
   .dens_ok     (dens_ok),
   .freq_ok     (freq_ok)
);

// File: tb/test_rx_link_watch.sv
`timescale 1ns/1ps
module test_rx_link_watch;
   localparam int CHAR_W   = 10;
   localparam int MAX_RUN  = 20;
   localparam int WIN_LOG2 = 10;
   localparam int PPM_TOL  = 20000;
   localparam int QUAL     = 2 ** WIN_LOG2;

   localparam logic [CHAR_W-1:0] ALT   = 10'b0101010101;
   localparam logic [CHAR_W-1:0] ONES  = 10'b1111111111;
   localparam logic [CHAR_W-1:0] END0  = 10'b1010101010;
   localparam logic [CHAR_W-1:0] END1  = 10'b1010101011;

   logic              rec_clk = 1'b0;
   logic              ref_clk = 1'b0;
   logic              rec_run = 1'b1;
   realtime           ref_half = 4.0;
   logic              rst_n = 1'b0;
   logic              amp = 1'b1;
   logic              carr = 1'b1;
   logic [CHAR_W-1:0] rx = ALT;
   logic              link_fault_n, track_ref;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   rx_link_watch #(
      .CHAR_W  (CHAR_W),
      .MAX_RUN (MAX_RUN),
      .WIN_LOG2(WIN_LOG2),
      .PPM_TOL (PPM_TOL)
   ) i_rx_link_watch (
      .rec_clk      (rec_clk),
      .ref_clk      (ref_clk),
      .rst_n        (rst_n),
      .amp_ok_async (amp),
      .carrier_async(carr),
      .rx_char      (rx),
      .link_fault_n (link_fault_n),
      .track_ref    (track_ref)
   );

   // 125 MHz recovered clock that can be stopped
   initial forever begin
      #4;
      if (rec_run) rec_clk = ~rec_clk;
   end

   initial forever begin
      #(ref_half);
      ref_clk = ~ref_clk;
   end

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge rec_clk);
   endtask

   // behavioural model: cycles since the last bad directly driven condition
   int m_run  = 0;
   int m_last = 0;
   int streak = 0;

   always @(posedge rec_clk) begin
      if (!rst_n) begin
         m_run = 0; m_last = 0; streak = 0;
      end else begin
         bit bad;
         bad = !amp || !carr;
         for (int i = 0; i < CHAR_W; i++) begin
            if (int'(rx[i]) == m_last) m_run++;
            else m_run = 1;
            m_last = int'(rx[i]);
            if (m_run > MAX_RUN) bad = 1'b1;
         end
         if (bad) streak = 0;
         else streak++;
      end
   end

   // per-cycle comparison: R9, no healthy indication inside a fresh window
   always @(negedge rec_clk) begin
      if (rst_n && !done && streak >= 4 && streak < QUAL - 4)
         chk("R9 per-cycle", int'(link_fault_n), 0);
   end

   initial begin
      #2ms;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      cyc(5);
      chk("R1 fault", int'(link_fault_n), 0);
      chk("R1 track", int'(track_ref), 1);
      rst_n = 1'b1;

      cyc(100);
      chk("R9 early", int'(link_fault_n), 0);
      cyc(3400);
      chk("R6 in band", int'(track_ref), 0);
      chk("R2 lock", int'(link_fault_n), 1);

      // R3 amplitude loss through the synchronizer
      amp = 1'b0;
      cyc(1);
      chk("R3 latency", int'(link_fault_n), 1);
      cyc(3);
      chk("R3 fault", int'(link_fault_n), 0);
      amp = 1'b1;
      cyc(500);
      chk("R9 after amp", int'(link_fault_n), 0);
      cyc(700);
      chk("R2 relock amp", int'(link_fault_n), 1);

      // R4 carrier loss
      carr = 1'b0;
      cyc(1);
      chk("R4 latency", int'(link_fault_n), 1);
      cyc(3);
      chk("R4 fault", int'(link_fault_n), 0);
      carr = 1'b1;
      cyc(1200);
      chk("R2 relock carr", int'(link_fault_n), 1);

      // R5 run of exactly MAX_RUN is tolerated
      rx = ONES; cyc(1);
      rx = ONES; cyc(1);
      rx = END0; cyc(1);
      rx = ALT;  cyc(5);
      chk("R5 run 20", int'(link_fault_n), 1);
      // R5 run of MAX_RUN+1 faults
      rx = ONES; cyc(1);
      rx = ONES; cyc(1);
      rx = END1; cyc(1);
      rx = ALT;  cyc(3);
      chk("R5 run 21", int'(link_fault_n), 0);
      cyc(1200);
      chk("R2 relock dens", int'(link_fault_n), 1);

      // R6 reference 10 percent slow: count far above the band
      ref_half = 4.4;
      cyc(2600);
      chk("R6 track", int'(track_ref), 1);
      chk("R6 fault", int'(link_fault_n), 0);
      ref_half = 4.0;
      cyc(2600);
      chk("R7 back", int'(track_ref), 0);
      cyc(1200);
      chk("R2 relock freq", int'(link_fault_n), 1);

      // R8 recovered clock stopped: output holds
      rec_run = 1'b0;
      carr = 1'b0;
      #200;
      chk("R8 hold", int'(link_fault_n), 1);
      rec_run = 1'b1;
      cyc(6);
      chk("R8 resume", int'(link_fault_n), 0);
      carr = 1'b1;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule